// File: doc/BRIEF.md
# Segmented MMU Address Translator

This block maps a 16-bit virtual address onto an 18-bit or 22-bit physical address. The virtual space of each privilege mode is cut into eight 8 KB segments, picked by the top three address bits. Each segment has a relocation base counted in 64-byte granules and a descriptor. The descriptor holds a length limit, an expansion direction and a three-bit access code. Kernel, supervisor and user modes each own an instruction table and a data table. A mode's data table is used only when the separate-data-space bit for that mode is set.

A register port reads and writes every table entry and the two status registers. A translation port returns the physical address, an abort flag with a three-bit cause and a trap request, all combinationally, in the same cycle as the request. On the clock edge that ends a request, the block records side effects. A permitted access sets the descriptor's accessed flag, and a permitted write also sets its written flag. An abort latches its cause into the control register. A taken trap sets a trap-seen bit.

Top module: `seg_xlate`

## Requirements
- R1: Reset clears the control register (address 0x80) and the configuration register (address 0x81) to zero, which turns mapping off.
- R2: Register address map: bit 7 set selects a status register, with bit 0 choosing control (0) or configuration (1). Bit 7 clear selects a table entry. Bit 6 chooses descriptor (0) or base (1), bits 5:4 give the mode, bit 3 the space (0 instruction, 1 data) and bits 2:0 the segment. Base entries read back all 16 bits. Descriptor writes keep only bits 14:8, 3 and 2:0, and clear bits 7 and 6. Control keeps bits 15:12, 9 and 0. Configuration keeps bits 4 and 2:0. Writes to mode 2 are ignored, and reads of mode 2 return zero.
- R3: With mapping on (control bit 0), the physical address is base×64 plus VA[12:0]. The segment comes from VA[15:13]. When configuration bit 4 is set, all 16 base bits take part (22-bit mode).
- R4: When configuration bit 4 is clear, base bits 15:12 are ignored and the result is cut to 18 bits, so physical bits 21:18 are zero.
- R5: Mode encoding is 0 kernel, 1 supervisor, 3 user. A data-side request uses the data table only if configuration bit 2 (kernel), bit 1 (supervisor) or bit 0 (user) is set, and uses the instruction table otherwise. Mode 2 always aborts as non-resident.
- R6: With mapping off, the physical address equals the VA, except that a VA in 0xE000..0xFFFF maps to 0x3FE000 plus VA[12:0]. No abort and no trap occur.
- R7: Access codes 0, 3 and 7 abort as non-resident. Codes 1 and 2 abort writes as read-only. Codes 4, 5 and 6 permit reads and writes. The cause bits are [2] non-resident, [1] length and [0] read-only. A non-resident abort reports only bit 2.
- R8: The length check uses the block number VA[12:6] and the length field (descriptor bits 14:8). When the expansion bit (descriptor bit 3) is clear, a block above the length aborts. When it is set, a block below the length aborts.
- R9: A trap is requested on a permitted access when the code is 1 and the access is a read, when the code is 4, or when the code is 5 and the access is a write, and only if control bit 9 is set. A trap sets control bit 12.
- R10: An abort loads its cause into control bits 15:13 (non-resident, length, read-only) only while those bits are all zero. Otherwise they hold until software rewrites them.
- R11: A permitted access sets descriptor bit 7, and a permitted write also sets bit 6. An aborted access leaves the descriptor unchanged.
- R12: Without a request, the abort, cause and trap outputs are zero and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the status registers |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| xl_req | input | 1 | Translation request |
| xl_va | input | 16 | Virtual address |
| xl_mode | input | 2 | Privilege mode |
| xl_dspace | input | 1 | Data-side reference |
| xl_write | input | 1 | Write access |
| xl_pa | output | 22 | Physical address |
| xl_abort | output | 1 | Access aborted |
| xl_cause | output | 3 | Abort cause: non-resident, length, read-only |
| xl_trap | output | 1 | Trap request |

## Verification
A wrong base or table index appears on xl_pa in the same cycle as the request. The bench therefore sweeps every mode, space and segment in both address widths. A wrong access-code decode shows up at once on the abort, cause and trap outputs. Errors in the edge-triggered state show up one cycle later: a flag set on the wrong descriptor, a lost abort latch or a latch that did not freeze. These appear on the next register read, which the bench performs after each request.

// File: rtl/seg_xlate.sv
module seg_xlate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        xl_req,
  input  logic [15:0] xl_va,
  input  logic [1:0]  xl_mode,
  input  logic        xl_dspace,
  input  logic        xl_write,
  output logic [21:0] xl_pa,
  output logic        xl_abort,
  output logic [2:0]  xl_cause,
  output logic        xl_trap
);
  localparam logic [15:0] DESC_MASK = 16'h7F0F;
  localparam logic [15:0] ST0_MASK  = 16'hF201;
  localparam logic [15:0] ST3_MASK  = 16'h0017;

  logic [15:0] desc [64];
  logic [15:0] base [64];
  logic [15:0] st0, st3;

  logic        map_on, e22, dsp_en, permit, may_trap;
  logic        hit_nonres, hit_len, hit_ro, wr_tab;
  logic [5:0]  xi;
  logic [15:0] dsc, bas;
  logic [6:0]  blk;
  logic [2:0]  acf;
  logic [21:0] rel;

  assign map_on = st0[0];
  assign e22    = st3[4];

  always_comb
    case (xl_mode)
      2'd0:    dsp_en = st3[2];
      2'd1:    dsp_en = st3[1];
      default: dsp_en = st3[0];
    endcase

  assign xi  = {xl_mode, xl_dspace & dsp_en, xl_va[15:13]};
  assign dsc = desc[xi];
  assign bas = base[xi];
  assign acf = dsc[2:0];
  assign blk = xl_va[12:6];

  assign hit_nonres = (xl_mode == 2'd2) || acf == 3'd0 || acf == 3'd3 || acf == 3'd7;
  assign hit_len    = !hit_nonres && (dsc[3] ? (blk < dsc[14:8]) : (blk > dsc[14:8]));
  assign hit_ro     = !hit_nonres && xl_write && (acf == 3'd1 || acf == 3'd2);
  assign permit     = !(hit_nonres || hit_len || hit_ro);
  assign may_trap   = (acf == 3'd1 && !xl_write) || acf == 3'd4 || (acf == 3'd5 && xl_write);

  assign rel = {(e22 ? bas[15:12] : 4'b0), bas[11:0], 6'b0} + {9'b0, xl_va[12:0]};

  assign xl_pa    = !map_on ? ((&xl_va[15:13]) ? {9'h1FF, xl_va[12:0]} : {6'b0, xl_va})
                            : (e22 ? rel : {4'b0, rel[17:0]});
  assign xl_abort = xl_req && map_on && !permit;
  assign xl_cause = xl_abort ? {hit_nonres, hit_len, hit_ro} : 3'b0;
  assign xl_trap  = xl_req && map_on && permit && may_trap && st0[9];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[7])
      reg_rdata = reg_addr[0] ? st3 : st0;
    else if (reg_addr[5:4] != 2'd2)
      reg_rdata = reg_addr[6] ? base[reg_addr[5:0]] : desc[reg_addr[5:0]];
  end

  assign wr_tab = reg_we && !reg_addr[7] && reg_addr[5:4] != 2'd2;

  always_ff @(posedge clk) begin
    if (xl_req && map_on && permit) begin
      desc[xi][7] <= 1'b1;
      if (xl_write) desc[xi][6] <= 1'b1;
    end
    if (wr_tab) begin
      if (reg_addr[6]) base[reg_addr[5:0]] <= reg_wdata;
      else             desc[reg_addr[5:0]] <= reg_wdata & DESC_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st0 <= '0;
      st3 <= '0;
    end else begin
      if (xl_abort && st0[15:13] == 3'b0) st0[15:13] <= xl_cause;
      if (xl_trap) st0[12] <= 1'b1;
      if (reg_we && reg_addr[7]) begin
        if (reg_addr[0]) st3 <= reg_wdata & ST3_MASK;
        else             st0 <= reg_wdata & ST0_MASK;
      end
    end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [7:0]  reg_addr,
  input logic        xl_req,
  input logic [21:0] xl_pa,
  input logic        xl_abort,
  input logic [2:0]  xl_cause,
  input logic        xl_trap,
  input logic [15:0] st0,
  input logic [15:0] st3
);
  logic st0_wr;
  assign st0_wr = reg_we && reg_addr[7] && !reg_addr[0];

  a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !st0[0] |-> (!xl_abort && !xl_trap));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |-> (!xl_abort && !xl_trap && xl_cause == 3'b0));

  a_r7_cause_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
    xl_abort |-> (xl_cause != 3'b0));

  a_r7_nonres_alone: assert property (@(posedge clk) disable iff (!rst_n)
    xl_cause[2] |-> (xl_cause[1:0] == 2'b0));

  a_r9_trap_gated: assert property (@(posedge clk) disable iff (!rst_n)
    xl_trap |-> (st0[9] && !xl_abort));

  a_r9_trap_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_trap && !st0_wr) |=> st0[12]);

  a_r4_18bit_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st0[0] && !st3[4]) |-> (xl_pa[21:18] == 4'b0));

  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    ((|st0[15:13]) && !st0_wr) |=> $stable(st0[15:13]));

  a_r10_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_abort && st0[15:13] == 3'b0 && !st0_wr) |=> (st0[15:13] == $past(xl_cause)));
endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        xl_req = 1'b0;
  logic [15:0] xl_va = '0;
  logic [1:0]  xl_mode = '0;
  logic        xl_dspace = 1'b0;
  logic        xl_write = 1'b0;
  logic [21:0] xl_pa;
  logic        xl_abort;
  logic [2:0]  xl_cause;
  logic        xl_trap;

  int nchk = 0, nerr = 0;
  logic [21:0] o_pa;
  logic        o_ab, o_tr;
  logic [2:0]  o_cs;
  logic [15:0] rv;

  seg_xlate u_dut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic xl(input logic rq, input logic [15:0] va, input logic [1:0] m,
                    input logic ds, input logic w);
    @(negedge clk);
    xl_req = rq; xl_va = va; xl_mode = m; xl_dspace = ds; xl_write = w;
    #1;
    o_pa = xl_pa; o_ab = xl_abort; o_cs = xl_cause; o_tr = xl_trap;
    @(negedge clk);
    xl_req = 1'b0;
  endtask

  function automatic logic [7:0] ta(input logic kind, input logic [1:0] m,
                                    input logic s, input logic [2:0] g);
    return {1'b0, kind, m, s, g};
  endfunction

  function automatic logic [15:0] bval(input int m, input int s, input int g);
    return 16'hA000 ^ 16'(m * 16'h0155 + s * 16'h0333 + g * 16'h0071);
  endfunction

  function automatic logic [1:0] menc(input int m);
    return (m == 2) ? 2'd3 : 2'(m);
  endfunction

  initial begin
    #(200000 * 4);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h80, rv); chk("R1 control after reset", 32'(rv), 32'h0);
    rd(8'h81, rv); chk("R1 config after reset", 32'(rv), 32'h0);

    // R6 unmapped pass-through
    xl(1, 16'h1234, 0, 0, 0); chk("R6 low VA", 32'(o_pa), 32'h1234);
    chk("R6 no abort", 32'({o_ab, o_tr}), 32'h0);
    xl(1, 16'hDFFF, 0, 0, 1); chk("R6 below top", 32'(o_pa), 32'hDFFF);
    xl(1, 16'hE010, 3, 1, 0); chk("R6 top segment", 32'(o_pa), 32'h3FE010);

    // R2 masks
    wr(8'h80, 16'hFFFF); rd(8'h80, rv); chk("R2 control mask", 32'(rv), 32'hF201);
    wr(8'h80, 16'h0000);
    wr(8'h81, 16'hFFFF); rd(8'h81, rv); chk("R2 config mask", 32'(rv), 32'h0017);
    wr(ta(0, 0, 0, 7), 16'hFFFF); rd(ta(0, 0, 0, 7), rv); chk("R2 descriptor mask", 32'(rv), 32'h7F0F);
    wr(ta(1, 2'd2, 0, 0), 16'h5555); rd(ta(1, 2'd2, 0, 0), rv); chk("R2 mode 2 ignored", 32'(rv), 32'h0);

    // table fill and readback
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 2; s++)
        for (int g = 0; g < 8; g++) begin
          wr(ta(0, menc(m), 1'(s), 3'(g)), 16'h7F06);
          wr(ta(1, menc(m), 1'(s), 3'(g)), bval(m, s, g));
        end
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 2; s++)
        for (int g = 0; g < 8; g++) begin
          rd(ta(1, menc(m), 1'(s), 3'(g)), rv);
          chk("R2 base readback", 32'(rv), 32'(bval(m, s, g)));
        end

    // R3, R4, R5 sweeps
    wr(8'h80, 16'h0001);
    for (int cfg = 0; cfg < 3; cfg++) begin
      wr(8'h81, cfg == 0 ? 16'h0017 : (cfg == 1 ? 16'h0007 : 16'h0010));
      for (int m = 0; m < 3; m++)
        for (int s = 0; s < 2; s++)
          for (int g = 0; g < 8; g++) begin
            logic [15:0] b;
            logic [21:0] e;
            b = bval(m, (cfg == 2) ? 0 : s, g);
            if (cfg == 1) e = 22'((32'(b[11:0]) * 64 + 32'h0ABC) & 32'h3FFFF);
            else          e = 22'(32'(b) * 64 + 32'h0ABC);
            xl(1, {3'(g), 13'h0ABC}, menc(m), 1'(s), 0);
            if (cfg == 0) chk("R3 22-bit relocation", 32'(o_pa), 32'(e));
            else if (cfg == 1) chk("R4 18-bit relocation", 32'(o_pa), 32'(e));
            else chk("R5 data uses instruction table", 32'(o_pa), 32'(e));
            chk("R3 no abort", 32'(o_ab), 32'h0);
          end
    end
    xl(1, 16'h0000, 2'd2, 0, 0);
    chk("R5 mode 2 non-resident", 32'({o_ab, o_cs}), 32'hC);
    wr(8'h80, 16'h0001);

    // R7, R9, R10, R11 access-code sweep (kernel instruction segment 0)
    for (int a = 0; a < 8; a++)
      for (int w = 0; w < 2; w++) begin
        logic nr, ro, ab, tp;
        logic [2:0] cs;
        nr = (a == 0 || a == 3 || a == 7);
        ro = !nr && w == 1 && (a == 1 || a == 2);
        ab = nr || ro;
        cs = nr ? 3'b100 : (ro ? 3'b001 : 3'b000);
        tp = !ab && ((a == 1 && w == 0) || a == 4 || (a == 5 && w == 1));
        wr(ta(0, 0, 0, 0), 16'h7F00 | 16'(a));
        wr(8'h80, 16'h0201);
        xl(1, 16'h0040, 0, 0, 1'(w));
        chk("R7 abort", 32'(o_ab), 32'(ab));
        chk("R7 cause", 32'(o_cs), 32'(cs));
        chk("R9 trap", 32'(o_tr), 32'(tp));
        rd(8'h80, rv);
        chk("R10 control latch", 32'(rv), 32'(16'h0201 | {cs, tp, 12'h0}));
        rd(ta(0, 0, 0, 0), rv);
        chk("R11 descriptor flags", 32'(rv),
            32'(16'h7F00 | 16'(a) | (ab ? 16'h0 : 16'h0080) | ((!ab && w == 1) ? 16'h0040 : 16'h0)));
      end

    // R9 trap disabled
    wr(ta(0, 0, 0, 0), 16'h7F04); wr(8'h80, 16'h0001);
    xl(1, 16'h0040, 0, 0, 0);
    chk("R9 trap off", 32'(o_tr), 32'h0);
    rd(8'h80, rv); chk("R9 no trap bit", 32'(rv), 32'h0001);

    // R8 length checks
    wr(ta(0, 0, 0, 0), 16'h0506);
    xl(1, 16'h0140, 0, 0, 0);
    chk("R8 up at limit", 32'(o_ab), 32'h0);
    chk("R8 up address", 32'(o_pa), 32'(22'(32'(bval(0, 0, 0)) * 64 + 32'h140)));
    xl(1, 16'h0180, 0, 0, 0);
    chk("R8 up beyond", 32'({o_ab, o_cs}), 32'hA);
    wr(8'h80, 16'h0001);
    wr(ta(0, 0, 0, 0), 16'h050E);
    xl(1, 16'h0140, 0, 0, 1); chk("R8 down at limit", 32'(o_ab), 32'h0);
    xl(1, 16'h0100, 0, 0, 0); chk("R8 down below", 32'({o_ab, o_cs}), 32'hA);
    wr(8'h80, 16'h0001);

    // R10 freeze and R12 idle
    wr(ta(0, 0, 0, 1), 16'h7F00);
    wr(ta(0, 0, 0, 2), 16'h7F02);
    xl(0, 16'h2000, 0, 0, 0);
    chk("R12 idle no abort", 32'(o_ab), 32'h0);
    rd(8'h80, rv); chk("R12 control untouched", 32'(rv), 32'h0001);
    xl(1, 16'h2000, 0, 0, 0);
    xl(1, 16'h4000, 0, 0, 1);
    chk("R7 read-only cause", 32'(o_cs), 32'h1);
    rd(8'h80, rv); chk("R10 frozen first cause", 32'(rv), 32'h8001);
    wr(8'h80, 16'h0001);
    xl(1, 16'h4000, 0, 0, 1);
    rd(8'h80, rv); chk("R10 relatch after clear", 32'(rv), 32'h2001);
    rd(ta(0, 0, 0, 2), rv); chk("R11 aborted leaves flags", 32'(rv), 32'h7F02);

    // R1 reset again mid-run
    wr(8'h81, 16'h0017);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(8'h80, rv); chk("R1 control after second reset", 32'(rv), 32'h0);
    rd(8'h81, rv); chk("R1 config after second reset", 32'(rv), 32'h0);
    xl(1, 16'hF000, 0, 0, 0); chk("R1 mapping off", 32'(o_pa), 32'h3FF000);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule